// File: doc/BRIEF.md
# Windowed peripheral address decoder with identity words and interrupt collection

This block sits on the slave side of a processor's plain synchronous memory bus. The bus master sees every peripheral as ordinary memory and uses only single read and write cycles. The block splits a range of word addresses into equal windows. It turns each access that lands in a window into a one-hot enable for the submodule that owns that window, and it returns that submodule's read data through a registered return path.

Every window begins with two read-only words: an identification constant and a version constant. Start-up software reads them to confirm that the expected peripheral is present in the loaded configuration. In this block the submodules are stubs. Each stub has an interrupt pending flag, a mask flag and a set of scratch registers. Each stub's pending flag is set by its own event input. All masked pending flags are ORed into one interrupt output toward the processor. An address outside every window selects nothing and reads back a fixed marker word.

Top module: `mmio_window_decoder`

## Requirements
- R1: While reset is asserted, bus_rdata is 0, irq is 0 and periph_sel is 0. After reset, every pending flag and mask flag reads 0.
- R2: With the defaults, window i covers word addresses 0x20+16*i to 0x2F+16*i, and the low four address bits select the word k. During the same cycle as a read or write strobe to such an address, periph_sel equals 1<<i. With no strobe, periph_sel is 0.
- R3: A read or write to an address below 0x20 or above 0x5F asserts no periph_sel bit. Such a read returns 0xDEADBEEF. Such a write changes no word in any window.
- R4: Word 0 of window i reads 0x4D4D0000+i and word 1 reads 0x00010000+(i<<8). Writes to either word have no effect.
- R5: Words 4 to 15 of each window read back the last full 32-bit value written to them. They reset to 0.
- R6: A one-cycle pulse on irq_evt[i] sets the pending flag of window i. The flag reads as bit 0 of word 2, and the other bits of word 2 read 0.
- R7: Writing a word with bit 0 = 1 to word 2 clears that window's pending flag, and bit 0 = 0 leaves it unchanged. If an event and a clearing write hit in the same cycle, the flag ends up set.
- R8: Bit 0 of word 3 is the window's mask flag, which is writable and reads back with the other bits 0. irq is the OR over all windows of (pending AND mask) and follows the flag registers without further delay.
- R9: bus_rdata is updated only at a clock edge where bus_rd is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Word address from the bus master |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| irq_evt | input | 4 | Per-window event pulses that set pending flags |
| bus_rdata | output | 32 | Registered read data |
| periph_sel | output | 4 | One-hot submodule enable, combinational from address and strobe |
| irq | output | 1 | Masked OR of all pending flags |

## Verification
periph_sel is combinational, so the bench checks it shortly after driving address and strobe, within the same cycle. Read data goes through one register, so the bench samples bus_rdata just after the rising edge that captures bus_rd. Pending and mask flags change at the edge that samples the event or write. irq is therefore checked just after that edge, and the new flag value is read back by the next read cycle. All inputs change at falling edges, so each sample falls away from the edge that produced it.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  // word offsets inside every window; software relies on this order
  localparam int OFF_IDENT = 0;
  localparam int OFF_REV   = 1;
  localparam int OFF_PEND  = 2;
  localparam int OFF_MASK  = 3;
  localparam int OFF_SCR0  = 4;
endpackage

// File: rtl/mmio_addr_dec.sv
module mmio_addr_dec #(
  parameter int ADDR_W    = 8,
  parameter int N_WIN     = 4,
  parameter int WIN_WORDS = 16,
  parameter int BASE      = 32,
  localparam int OFF_W    = $clog2(WIN_WORDS),
  localparam int SPAN     = N_WIN * WIN_WORDS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [N_WIN-1:0]  sel,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  logic [ADDR_W:0]   rel_ext;
  logic [ADDR_W-1:0] win_idx;

  always_comb begin
    rel_ext = {1'b0, addr} - (ADDR_W+1)'(BASE);
    hit     = !rel_ext[ADDR_W] && (rel_ext < (ADDR_W+1)'(SPAN));
    win_idx = rel_ext[ADDR_W-1:0] >> OFF_W;
    off     = rel_ext[OFF_W-1:0];
  end

  for (genvar i = 0; i < N_WIN; i++) begin : g_sel
    assign sel[i] = (rd || wr) && hit && (win_idx == ADDR_W'(i));
  end
endmodule

// File: rtl/mmio_periph_stub.sv
module mmio_periph_stub
  import mmio_pkg::*;
#(
  parameter int DATA_W              = 32,
  parameter int WIN_WORDS           = 16,
  parameter logic [DATA_W-1:0] IDENT = '0,
  parameter logic [DATA_W-1:0] REV   = '0,
  localparam int OFF_W              = $clog2(WIN_WORDS),
  localparam int N_SCR              = WIN_WORDS - OFF_SCR0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  output logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic              mask
);
  logic              pend_q, pend_d, mask_q, mask_d, wen;
  logic [DATA_W-1:0] scr_q [N_SCR];
  logic [DATA_W-1:0] scr_d [N_SCR];

  assign wen = sel && wr;

  always_comb begin
    pend_d = evt || (pend_q && !(wen && off == OFF_W'(OFF_PEND) && wdata[0]));
    mask_d = (wen && off == OFF_W'(OFF_MASK)) ? wdata[0] : mask_q;
    scr_d  = scr_q;
    for (int k = 0; k < N_SCR; k++)
      if (wen && off == OFF_W'(k + OFF_SCR0)) scr_d[k] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
      for (int k = 0; k < N_SCR; k++) scr_q[k] <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      scr_q  <= scr_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (off == OFF_W'(OFF_IDENT))     rdata = IDENT;
    else if (off == OFF_W'(OFF_REV))  rdata = REV;
    else if (off == OFF_W'(OFF_PEND)) rdata = {{(DATA_W-1){1'b0}}, pend_q};
    else if (off == OFF_W'(OFF_MASK)) rdata = {{(DATA_W-1){1'b0}}, mask_q};
    else
      for (int k = 0; k < N_SCR; k++)
        if (off == OFF_W'(k + OFF_SCR0)) rdata = scr_q[k];
  end

  assign pend = pend_q;
  assign mask = mask_q;

  // R6: a pending flag only rises after its event input
  p_pend_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(evt));
  // R7: a clearing write without a competing event drops the flag
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && off == OFF_W'(OFF_PEND) && wdata[0] && !evt) |=> !pend_q);
  // R8: mask flag moves only on a write to its word
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen && off == OFF_W'(OFF_MASK)) |=> $stable(mask_q));
endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder #(
  parameter int ADDR_W               = 8,
  parameter int DATA_W               = 32,
  parameter int N_WIN                = 4,
  parameter int WIN_WORDS            = 16,
  parameter int BASE                 = 32,
  parameter logic [DATA_W-1:0] IDENT_BASE = 32'h4D4D_0000,
  parameter logic [DATA_W-1:0] REV_BASE   = 32'h0001_0000,
  parameter logic [DATA_W-1:0] MISS_DATA  = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_WIN-1:0]  irq_evt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_WIN-1:0]  periph_sel,
  output logic              irq
);
  localparam int OFF_W = $clog2(WIN_WORDS);

  logic [N_WIN-1:0]  sel, pend, mask;
  logic              hit;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] win_rdata [N_WIN];
  logic [DATA_W-1:0] mux_data, rdata_d, rdata_q;

  mmio_addr_dec #(
    .ADDR_W(ADDR_W), .N_WIN(N_WIN), .WIN_WORDS(WIN_WORDS), .BASE(BASE)
  ) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel), .hit(hit), .off(off)
  );

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    mmio_periph_stub #(
      .DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS),
      .IDENT(IDENT_BASE + DATA_W'(i)),
      .REV(REV_BASE + (DATA_W'(i) << 8))
    ) u_stub (
      .clk(clk), .rst_n(rst_n), .sel(sel[i]), .wr(bus_wr), .off(off),
      .wdata(bus_wdata), .evt(irq_evt[i]), .rdata(win_rdata[i]),
      .pend(pend[i]), .mask(mask[i])
    );
  end

  always_comb begin
    mux_data = '0;
    for (int i = 0; i < N_WIN; i++)
      if (sel[i]) mux_data = mux_data | win_rdata[i];
    rdata_d = hit ? mux_data : MISS_DATA;
  end

  // read return register, enabled by the read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata  = rdata_q;
  assign periph_sel = sel;
  assign irq        = |(pend & mask);

  // R2: never more than one enable, and only with a strobe
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  p_sel_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> (bus_rd || bus_wr));
  // R3: a miss selects nothing and returns the marker word
  p_miss_nosel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (sel == '0));
  p_miss_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == MISS_DATA));
  // R9: read data holds without a read strobe
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_mmio_window_decoder.sv
module sim_mmio_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata;
  logic [3:0]  irq_evt;
  logic [31:0] bus_rdata;
  logic [3:0]  periph_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_scr [4][12];
  logic        m_pend [4];
  logic        m_mask [4];

  always #10 clk = ~clk;

  mmio_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_evt(irq_evt),
    .bus_rdata(bus_rdata), .periph_sel(periph_sel), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_win(int a);
    return (a >= 32) && (a < 96);
  endfunction

  function automatic logic [3:0] exp_sel(int a);
    return in_win(a) ? 4'(1 << ((a - 32) / 16)) : 4'h0;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    int w, k;
    if (!in_win(a)) return 32'hDEAD_BEEF;
    w = (a - 32) / 16;
    k = (a - 32) % 16;
    case (k)
      0: return 32'h4D4D_0000 + 32'(w);
      1: return 32'h0001_0000 + 32'(w << 8);
      2: return {31'b0, m_pend[w]};
      3: return {31'b0, m_mask[w]};
      default: return m_scr[w][k-4];
    endcase
  endfunction

  function automatic string tag_of(int a);
    int k;
    if (!in_win(a)) return "R3";
    k = (a - 32) % 16;
    if (k < 2) return "R4";
    if (k == 2) return "R6";
    if (k == 3) return "R8";
    return "R5";
  endfunction

  function automatic logic [31:0] pat(int a);
    return {8'(a), 8'hA5, ~8'(a), 8'(a) ^ 8'h3C};
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < 4; i++) r |= m_pend[i] & m_mask[i];
    return r;
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    int w, k;
    if (!in_win(a)) return;
    w = (a - 32) / 16;
    k = (a - 32) % 16;
    if (k == 2 && d[0]) m_pend[w] = 1'b0;
    else if (k == 3) m_mask[w] = d[0];
    else if (k >= 4) m_scr[w][k-4] = d;
  endtask

  task automatic do_write(int a, logic [31:0] d, string req);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0; irq_evt = '0;
    #1 check({req, " R2 sel on write"}, 32'(periph_sel), 32'(exp_sel(a)));
    @(posedge clk);
    model_write(a, d);
    #1;
  endtask

  task automatic do_read(int a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = 8'(a); bus_rd = 1'b1; bus_wr = 1'b0; irq_evt = '0;
    #1 check("R2 sel on read", 32'(periph_sel), 32'(exp_sel(a)));
    e = exp_rd(a);
    @(posedge clk);
    #1 check(req, bus_rdata, e);
  endtask

  task automatic pulse(int i);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; irq_evt = 4'(1 << i);
    @(posedge clk);
    m_pend[i] = 1'b1;
    #1 check("R8 irq after event", 32'(irq), 32'(exp_irq()));
    @(negedge clk);
    irq_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int w = 0; w < 4; w++) begin
      m_pend[w] = 1'b0; m_mask[w] = 1'b0;
      for (int k = 0; k < 12; k++) m_scr[w][k] = '0;
    end
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; irq_evt = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata in reset", bus_rdata, 32'h0);
    check("R1 irq in reset", 32'(irq), 32'h0);
    check("R1 sel in reset", 32'(periph_sel), 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R1: flags read zero after reset
    for (int w = 0; w < 4; w++) begin
      do_read(32 + 16*w + 2, "R1 pending after reset");
      do_read(32 + 16*w + 3, "R1 mask after reset");
    end
    do_read(32 + 16 + 7, "R5 scratch reset value");

    // full write sweep, including misses and read-only words (R3, R4)
    for (int a = 0; a < 256; a++) do_write(a, pat(a), "R3/R4 sweep");
    // full read sweep against the model
    for (int a = 0; a < 256; a++) do_read(a, tag_of(a));

    // R9: data holds with no read strobe
    do_read(32 + 16 + 5, "R5 readback");
    held = bus_rdata;
    @(negedge clk) bus_rd = 1'b0; bus_addr = 8'h00;
    repeat (3) @(posedge clk);
    #1 check("R9 hold without read", bus_rdata, held);

    // interrupt flow; every mask flag is 1 after the sweep
    check("R8 irq idle", 32'(irq), 32'(exp_irq()));
    pulse(2);
    do_read(32 + 32 + 2, "R6 pending set");
    do_read(32 + 2, "R6 other window clear");
    do_write(32 + 32 + 2, 32'hFFFF_FFFE, "R7 write 0 keeps");
    check("R7 write of 0 keeps irq", 32'(irq), 32'h1);
    do_read(32 + 32 + 2, "R7 pending kept");
    do_write(32 + 32 + 2, 32'h1, "R7 clear");
    check("R7 clear drops irq", 32'(irq), 32'h0);
    do_read(32 + 32 + 2, "R7 pending cleared");

    do_write(32 + 32 + 3, 32'h0, "R8 mask off");
    pulse(2);
    check("R8 masked irq", 32'(irq), 32'h0);
    do_read(32 + 32 + 2, "R6 masked pending still set");
    do_read(32 + 32 + 3, "R8 mask readback");
    do_write(32 + 32 + 2, 32'h1, "R7 clear");

    // R7: event and clearing write in the same cycle, event wins
    @(negedge clk);
    bus_addr = 8'(32 + 16 + 2); bus_wdata = 32'h1; bus_wr = 1'b1;
    bus_rd = 1'b0; irq_evt = 4'b0010;
    @(posedge clk);
    m_pend[1] = 1'b1;
    #1 check("R7 event beats clear irq", 32'(irq), 32'h1);
    @(negedge clk) irq_evt = '0; bus_wr = 1'b0;
    do_read(32 + 16 + 2, "R7 event beats clear");

    // each window raises the shared line on its own
    for (int w = 0; w < 4; w++) begin
      for (int v = 0; v < 4; v++) do_write(32 + 16*v + 2, 32'h1, "R7 clear all");
      do_write(32 + 16*w + 3, 32'h1, "R8 mask on");
      check("R8 irq low before event", 32'(irq), 32'h0);
      pulse(w);
      do_read(32 + 16*w + 2, "R6 pending per window");
    end

    @(negedge clk) bus_rd = 1'b0; bus_wr = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule